// File: doc/BRIEF.md
# Self-Clocked Serial Readout Port

This block is the device side of a serial read interface on a data converter, in the mode where the device generates the serial clock itself. A host pulls the active-low frame select low. An address input and a calibration selector then pick one of three registers: the control word, the calibration word or the conversion output register. The block drives a divided-down serial clock and shifts the chosen word out most significant bit first. When the frame ends it releases its clock and data pins to high impedance. Each pin has a data output and an output enable, and the enable going low stands for the high-impedance state.

Conversion results arrive as a parallel word with a one-cycle update strobe. The active-low ready flag says whether the output register holds a word that has not yet been read. Only new output words and the end of an output read move this flag. Control and calibration reads never look at it and never change it. A word that arrives while the output register is being read out is dropped, and the flag does not report it.

Top module: `srd_port`

## Requirements
- R1: While reset is high and on the cycle after it, `drdy_n` is 1 and both `sclk_oe` and `sdata_oe` are 0.
- R2: A frame with `addr`=0 reads the control word: 24 bits of `ctrl_word`, MSB first, whatever the state of `drdy_n`.
- R3: A frame with `addr`=1 and `cal_sel`=1 reads 24 bits of `cal_word`, MSB first, whatever the state of `drdy_n`.
- R4: A frame with `addr`=1 and `cal_sel`=0 (an output read) starts only while `drdy_n` is 0. If the frame select falls while `drdy_n` is 1, no clock or data is driven.
- R5: An update strobe outside an output read loads `upd_word` into the output register, and `drdy_n` is 0 on the next cycle. Without an intervening read, a later output read returns the most recent word.
- R6: After an output read, `drdy_n` returns to 1 on the same cycle that `sclk_oe` and `sdata_oe` drop. That cycle is the falling clock edge after the one that presented the LSB.
- R7: An update strobe during an output read is discarded. `drdy_n` stays 1 after the read, and no output read can start until another word arrives.
- R8: When `ctrl_word` bit 5 is 1, an output read transfers 16 bits, which are bits 23..8 of the output register. Control and calibration reads stay at 24 bits.
- R9: `sclk_o` is the system clock divided by 4: low for 2 cycles, then high for 2 cycles, per bit. On the first cycle of a frame it is low and the MSB is already on `sdata_o`. `sdata_o` changes only where `sclk_o` falls.
- R10: Control and calibration reads leave `drdy_n` unchanged.
- R11: A frame starts only on a 1-to-0 transition of `rfs_n`. Holding `rfs_n` low after a frame starts nothing further, even when a new word makes `drdy_n` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | One-cycle strobe: new conversion word |
| upd_word | input | 24 | New conversion word |
| ctrl_word | input | 24 | Control register contents; bit 5 selects 16-bit output reads |
| cal_word | input | 24 | Calibration register contents |
| cal_sel | input | 1 | With addr=1: 1 selects calibration, 0 selects output register |
| addr | input | 1 | 0 selects control register, 1 selects output/calibration |
| rfs_n | input | 1 | Active-low read frame select |
| sclk_o | output | 1 | Generated serial clock (idles high) |
| sclk_oe | output | 1 | Serial clock drive enable |
| sdata_o | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Serial data drive enable |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
The hardest case to reach is an update strobe that lands in the middle of an output read. The lost word has no visible effect except that `drdy_n` stays high afterwards. The bench forks a strobe into a running output frame, then checks that the read returned the older word. It also checks that `drdy_n` stays high and that a following output frame is refused. A second hard case is a frame select held low across the end of a transfer while a new word arrives; it shows that only a fresh falling edge starts a read.

// File: rtl/srd_pkg.sv
package srd_pkg;

    // Register chosen for a read frame
    typedef enum logic [1:0] {
        SRC_CTRL = 2'd0,
        SRC_CAL  = 2'd1,
        SRC_OUT  = 2'd2
    } src_e;

endpackage

// File: rtl/srd_seq.sv
// Frame sequencer: start decision, clock phase, bit count
module srd_seq
    import srd_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    parameter int DIV     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rfs_n,
    input  logic addr,
    input  logic cal_sel,
    input  logic drdy_n,
    input  logic len16,
    output logic active,
    output src_e src,
    output logic start,
    output logic shift_en,
    output logic done,
    output logic sclk
);
    localparam int PH_W  = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int HALF  = DIV / 2;

    typedef struct packed {
        logic             active;
        src_e             src;
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] bitn;
        logic [CNT_W-1:0] nbits;
        logic             rfs_prev;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        start    = 1'b0;
        shift_en = 1'b0;
        done     = 1'b0;
        d.rfs_prev = rfs_n;
        if (!q.active) begin
            if (q.rfs_prev && !rfs_n) begin
                if (!addr) begin
                    start   = 1'b1;
                    d.src   = SRC_CTRL;
                    d.nbits = CNT_W'(WORD_W);
                end else if (cal_sel) begin
                    start   = 1'b1;
                    d.src   = SRC_CAL;
                    d.nbits = CNT_W'(WORD_W);
                end else if (!drdy_n) begin
                    start   = 1'b1;
                    d.src   = SRC_OUT;
                    d.nbits = len16 ? CNT_W'(SHORT_W) : CNT_W'(WORD_W);
                end
            end
            if (start) begin
                d.active = 1'b1;
                d.ph     = '0;
                d.bitn   = '0;
            end
        end else begin
            if (q.ph == PH_W'(DIV - 1)) begin
                d.ph = '0;
                if (q.bitn == q.nbits - CNT_W'(1)) begin
                    done     = 1'b1;
                    d.active = 1'b0;
                end else begin
                    shift_en = 1'b1;
                    d.bitn   = q.bitn + CNT_W'(1);
                end
            end else begin
                d.ph = q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.active   <= 1'b0;
            q.src      <= SRC_CTRL;
            q.ph       <= '0;
            q.bitn     <= '0;
            q.nbits    <= '0;
            q.rfs_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign active = q.active;
    assign src    = q.src;
    assign sclk   = !q.active || (q.ph >= PH_W'(HALF));

endmodule

// File: rtl/srd_shift.sv
// Parallel-load, MSB-first shift register
module srd_shift #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_en,
    output logic              msb
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.sh = load_word;
        end else if (shift_en) begin
            d.sh = {q.sh[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.sh <= '0;
        end else begin
            q <= d;
        end
    end

    assign msb = q.sh[WORD_W-1];

endmodule

// File: rtl/srd_ready.sv
// Output register and its active-low ready flag
module srd_ready #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [WORD_W-1:0] upd_word,
    input  logic              out_busy,
    input  logic              out_done,
    output logic [WORD_W-1:0] out_word,
    output logic              drdy_n
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              rdy_n;
    } rdy_t;

    rdy_t q, d;

    always_comb begin
        d = q;
        // words arriving during an output read are dropped
        if (upd_valid && !out_busy) begin
            d.word  = upd_word;
            d.rdy_n = 1'b0;
        end
        if (out_done) begin
            d.rdy_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.word  <= '0;
            q.rdy_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign out_word = q.word;
    assign drdy_n   = q.rdy_n;

endmodule

// File: rtl/srd_port.sv
module srd_port
    import srd_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int SHORT_W  = 16,
    parameter int DIV      = 4,
    parameter int WL16_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [WORD_W-1:0] upd_word,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] cal_word,
    input  logic              cal_sel,
    input  logic              addr,
    input  logic              rfs_n,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic              drdy_n
);
    logic              active, start, shift_en, done, sclk, msb;
    logic              len16, out_busy, out_done;
    src_e              src, src_next;
    logic [WORD_W-1:0] out_word, load_word;

    assign len16 = ctrl_word[WL16_BIT];

    srd_seq #(
        .WORD_W (WORD_W),
        .SHORT_W(SHORT_W),
        .DIV    (DIV)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .rfs_n   (rfs_n),
        .addr    (addr),
        .cal_sel (cal_sel),
        .drdy_n  (drdy_n),
        .len16   (len16),
        .active  (active),
        .src     (src),
        .start   (start),
        .shift_en(shift_en),
        .done    (done),
        .sclk    (sclk)
    );

    // Source selected at the start edge, decoded from the same inputs
    always_comb begin
        if (!addr) begin
            src_next = SRC_CTRL;
        end else if (cal_sel) begin
            src_next = SRC_CAL;
        end else begin
            src_next = SRC_OUT;
        end
        case (src_next)
            SRC_CTRL: load_word = ctrl_word;
            SRC_CAL:  load_word = cal_word;
            default:  load_word = out_word;
        endcase
    end

    srd_shift #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_word(load_word),
        .shift_en (shift_en),
        .msb      (msb)
    );

    assign out_busy = active && (src == SRC_OUT);
    assign out_done = done && (src == SRC_OUT);

    srd_ready #(
        .WORD_W(WORD_W)
    ) u_ready (
        .clk      (clk),
        .rst      (rst),
        .upd_valid(upd_valid),
        .upd_word (upd_word),
        .out_busy (out_busy),
        .out_done (out_done),
        .out_word (out_word),
        .drdy_n   (drdy_n)
    );

    assign sclk_o   = sclk;
    assign sclk_oe  = active;
    assign sdata_o  = msb;
    assign sdata_oe = active;

endmodule

// File: rtl/srd_chk.sv
module srd_chk #(
    parameter int HALF = 2
) (
    input logic clk,
    input logic rst,
    input logic addr,
    input logic cal_sel,
    input logic upd_valid,
    input logic sclk_o,
    input logic sclk_oe,
    input logic sdata_o,
    input logic sdata_oe,
    input logic drdy_n
);
    logic       rst_seen;
    logic       sclk_prev, oe_prev;
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        rst_seen  <= rst;
        sclk_prev <= sclk_o;
        oe_prev   <= sclk_oe;
        if (!sclk_oe) begin
            run_q <= 8'd0;
        end else if (sclk_o != sclk_prev) begin
            run_q <= 8'd1;
        end else begin
            run_q <= run_q + 8'd1;
        end
    end

    // R1: idle outputs after reset
    always_ff @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            p_reset_r1: assert (drdy_n && !sclk_oe && !sdata_oe)
                else $error("reset state wrong");
        end
    end

    // R9: each clock level lasts half the divide ratio
    always_ff @(posedge clk) begin
        if (!rst && rst_seen === 1'b0 && sclk_oe && oe_prev && (sclk_o != sclk_prev)) begin
            p_half_period_r9: assert (run_q == 8'(HALF))
                else $error("sclk level length %0d", run_q);
        end
    end

    p_start_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_oe) |-> !sclk_o);

    p_data_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (sdata_oe && $past(sdata_oe) && !$stable(sdata_o)) |-> $fell(sclk_o));

    p_out_needs_ready_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk_oe) && addr && !cal_sel) |-> $past(!drdy_n));

    p_ready_rise_end_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> $fell(sclk_oe));

    p_ready_fall_upd_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_n) |-> $past(upd_valid));

    p_ctrl_keep_ready_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk_oe) && (!addr || cal_sel)) |-> !$rose(drdy_n));

endmodule

bind srd_port srd_chk #(.HALF(DIV / 2)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .cal_sel  (cal_sel),
    .upd_valid(upd_valid),
    .sclk_o   (sclk_o),
    .sclk_oe  (sclk_oe),
    .sdata_o  (sdata_o),
    .sdata_oe (sdata_oe),
    .drdy_n   (drdy_n)
);

// File: tb/sim_srd_port.sv
`timescale 1ns/1ps
module sim_srd_port;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         upd_valid = 1'b0;
    logic [W-1:0] upd_word = '0;
    logic [W-1:0] ctrl_word = 24'hA5C396;
    logic [W-1:0] cal_word = 24'h3C5AE1;
    logic         cal_sel = 1'b0;
    logic         addr = 1'b0;
    logic         rfs_n = 1'b1;
    logic         sclk_o, sclk_oe, sdata_o, sdata_oe, drdy_n;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    srd_port u0 (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_word(upd_word),
        .ctrl_word(ctrl_word), .cal_word(cal_word), .cal_sel(cal_sel),
        .addr(addr), .rfs_n(rfs_n), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .drdy_n(drdy_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] w);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_word  = w;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic do_frame(input logic a, input logic cs, input bit keep_low,
                            output bit started, output logic [31:0] got, output int nb,
                            output int cyc, output bit tbad, output logic drdy_end);
        logic ps, pd;
        int run, wait_n;
        started = 1'b0; got = '0; nb = 0; cyc = 0; tbad = 1'b0; drdy_end = drdy_n;
        @(negedge clk);
        addr = a; cal_sel = cs; rfs_n = 1'b0;
        wait_n = 0;
        @(negedge clk);
        while (sclk_oe !== 1'b1 && wait_n < 8) begin
            @(negedge clk);
            wait_n++;
        end
        if (sclk_oe === 1'b1) begin
            started = 1'b1; ps = 1'b1; pd = sdata_o; run = 0;
            if (sclk_o !== 1'b0) tbad = 1'b1;
            while (sclk_oe === 1'b1 && cyc < 1000) begin
                cyc++;
                if (sclk_o !== ps) begin
                    if (cyc > 1 && run != 2) tbad = 1'b1;
                    run = 1;
                end else begin
                    run++;
                end
                if (cyc > 1 && sdata_o !== pd && !(ps && !sclk_o)) tbad = 1'b1;
                if (sclk_o && !ps) begin
                    got = {got[30:0], sdata_o};
                    nb++;
                end
                ps = sclk_o; pd = sdata_o;
                @(negedge clk);
            end
            drdy_end = drdy_n;
        end
        if (!keep_low) rfs_n = 1'b1;
    endtask

    task automatic t_reset();
        chk(drdy_n === 1'b1, "R1 drdy_n", 32'(drdy_n), 1);
        chk(sclk_oe === 1'b0 && sdata_oe === 1'b0, "R1 enables", {sclk_oe, sdata_oe}, 0);
    endtask

    task automatic t_ctrl();
        bit s, tb; logic [31:0] g; int nb, cy; logic de;
        do_frame(1'b0, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && g == 32'(ctrl_word) && nb == 24, "R2 control word", g, 32'(ctrl_word));
        chk(cy == 96 && !tb, "R9 timing control read", cy, 96);
        chk(de === 1'b1, "R10 flag after control read", 32'(de), 1);
    endtask

    task automatic t_cal();
        bit s, tb; logic [31:0] g; int nb, cy; logic de;
        do_frame(1'b1, 1'b1, 1'b0, s, g, nb, cy, tb, de);
        chk(s && g == 32'(cal_word) && nb == 24 && !tb, "R3 calibration word", g, 32'(cal_word));
    endtask

    task automatic t_blocked();
        bit s, tb; logic [31:0] g; int nb, cy; logic de;
        do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(!s, "R4 output read refused while flag high", 32'(s), 0);
    endtask

    task automatic t_update();
        bit s, tb; logic [31:0] g; int nb, cy; logic de;
        push(24'h123456);
        chk(drdy_n === 1'b0, "R5 flag low after update", 32'(drdy_n), 0);
        push(24'hFEDCBA);
        do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && g == 32'hFEDCBA && nb == 24, "R5 latest word read", g, 32'hFEDCBA);
        chk(de === 1'b1 && cy == 96 && !tb, "R6 flag high at release", {de, 8'(cy)}, {1'b1, 8'd96});
        repeat (3) @(negedge clk);
        chk(drdy_n === 1'b1, "R6 flag stays high", 32'(drdy_n), 1);
    endtask

    task automatic t_ctrl_low();
        bit s, tb; logic [31:0] g; int nb, cy; logic de;
        push(24'h0F0F0F);
        do_frame(1'b0, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && de === 1'b0 && drdy_n === 1'b0, "R10 flag kept low across control read", 32'(de), 0);
        do_frame(1'b1, 1'b1, 1'b0, s, g, nb, cy, tb, de);
        chk(s && g == 32'(cal_word) && drdy_n === 1'b0, "R3 R10 calibration read with flag low", g, 32'(cal_word));
        do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && g == 32'h0F0F0F, "R5 pending word", g, 32'h0F0F0F);
    endtask

    task automatic t_lost();
        bit s, tb; logic [31:0] g; int nb, cy; logic de;
        push(24'h111111);
        fork
            do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
            begin
                repeat (40) @(negedge clk);
                upd_valid = 1'b1;
                upd_word  = 24'h222222;
                @(negedge clk);
                upd_valid = 1'b0;
            end
        join
        chk(s && g == 32'h111111, "R7 read returns older word", g, 32'h111111);
        repeat (5) @(negedge clk);
        chk(drdy_n === 1'b1, "R7 flag not set by lost word", 32'(drdy_n), 1);
        do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(!s, "R7 no read of lost word", 32'(s), 0);
        push(24'h333333);
        do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && g == 32'h333333, "R7 next word readable", g, 32'h333333);
    endtask

    task automatic t_len16();
        bit s, tb; logic [31:0] g; int nb, cy; logic de;
        ctrl_word = 24'hA5C3B6;
        push(24'hABCDEF);
        do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && nb == 16 && g == 32'hABCD, "R8 short output read", g, 32'hABCD);
        chk(cy == 64 && !tb && de === 1'b1, "R8 R6 short read end", cy, 64);
        do_frame(1'b0, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && nb == 24 && g == 32'hA5C3B6, "R8 control read stays 24 bits", g, 32'hA5C3B6);
        ctrl_word = 24'hA5C396;
    endtask

    task automatic t_edge();
        bit s, tb, seen; logic [31:0] g; int nb, cy; logic de;
        push(24'h445566);
        do_frame(1'b1, 1'b0, 1'b1, s, g, nb, cy, tb, de);
        chk(s && g == 32'h445566, "R11 first frame", g, 32'h445566);
        push(24'h778899);
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sclk_oe !== 1'b0) seen = 1'b1;
        end
        chk(!seen && drdy_n === 1'b0, "R11 no start while held low", 32'(seen), 0);
        @(negedge clk);
        rfs_n = 1'b1;
        do_frame(1'b1, 1'b0, 1'b0, s, g, nb, cy, tb, de);
        chk(s && g == 32'h778899, "R11 fresh edge starts read", g, 32'h778899);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_cal();
        t_blocked();
        t_update();
        t_ctrl_low();
        t_lost();
        t_len16();
        t_edge();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule